// File: doc/BRIEF.md
# Serial Transmit Path with Priority Bypass

This block is the transmit half of an asynchronous serial port. A host hands it bytes over a valid/ready stream. The bytes queue in a 32-entry FIFO, and a shifter sends each one as a character on a line that idles high. The block takes one baud tick per bit time from an outside rate generator. It also drives an active-low direction pin for a two-wire half-duplex transceiver. A level input sets the polarity of that pin.

A host that needs one byte to overtake the queue pulses `imm_set`. This arms a one-shot flag, `imm_pending`. The next byte accepted while the flag is armed goes into a single-byte priority holder instead of the FIFO. If the shifter is busy, that byte waits until the current character ends and then goes out before any byte still queued. The flag drops by itself when that byte's stop bit has finished. To send several bytes this way, the host must pulse `imm_set` again for each byte.

Stream rules: a beat transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. The block does not stall the source. A beat presented while `in_ready` is low is discarded, and the sticky `ovf` flag is set. A source that must not lose data waits for `in_ready`.

Top module: `uart_tx_bypass`

## Requirements
- R1: After reset, `txd`=1, `ovf`=0, `imm_pending`=0 and `in_ready`=1, and `rts_n` is at its idle level.
- R2: Each character is sent as a start bit (0), then 8 data bits with bit 0 first, then a stop bit (1). Every bit lasts from one `baud_tick` to the next. A character starts only on a tick, and `txd` changes only on the clock edge that samples a tick.
- R3: With `fifo_en`=1, the FIFO holds up to 32 bytes and sends them in the order they were written. `in_ready` is low while 32 bytes are queued and no bypass byte is expected.
- R4: A beat with `in_valid`=1 while `in_ready`=0 is dropped, is never sent, and sets `ovf`. `ovf` stays 1 until reset.
- R5: With `fifo_en`=1, a pulse on `imm_set` sets `imm_pending`. The next byte accepted then bypasses the FIFO. If a character is in progress, the bypass byte is sent immediately after it and ahead of all bytes already queued.
- R6: The flag covers exactly one byte. Bytes accepted after the bypass byte, while the flag is still set, go to the FIFO. A pulse on `imm_set` while the flag is already set has no effect.
- R7: `imm_pending` returns to 0 on its own when the bypass byte's stop bit ends, and not before.
- R8: With `fifo_en`=0, a pulse on `imm_set` is ignored and `imm_pending` stays 0.
- R9: With `fifo_en`=0, the queue holds a single byte. `in_ready` is low while that byte waits.
- R10: When `rts_inv`=0, `rts_n` is 0 from the start bit through the end of the stop bit, and 1 otherwise. When `rts_inv`=1, both levels are swapped. Back-to-back characters keep `rts_n` at the transmitting level without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| fifo_en | input | 1 | 1: 32-entry queue and bypass allowed; 0: single-byte queue |
| rts_inv | input | 1 | Swaps the levels of `rts_n` |
| imm_set | input | 1 | Pulse that arms the one-shot bypass flag |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Room for a beat |
| in_data | input | 8 | Stream byte |
| txd | output | 1 | Serial line, idles high |
| rts_n | output | 1 | Transceiver direction, active low by default |
| imm_pending | output | 1 | One-shot bypass flag |
| ovf | output | 1 | Sticky flag for a dropped beat |

## Verification
The hardest case to reach from the ports is a bypass byte that arrives while a character is on the line and other bytes are queued behind it. The bench stops the baud tick, writes a few bytes, and then restarts the tick. It waits until `rts_n` shows that the shifter has taken the first byte, and only then arms the flag and writes the bypass byte plus one more. The decoded line order shows whether the byte overtook the queue, and the flag is checked both while the byte waits and after it has gone. A full FIFO is reached the same way: the tick is held off while 33 bytes are offered.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } tx_phase_e;
endpackage

// File: rtl/uart_txb_fifo.sv
module uart_txb_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_txb_shifter.sv
module uart_txb_shifter
  import uart_txb_pkg::*;
#(
  parameter int DW = 8,
  localparam int BCW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          avail,
  input  logic [DW-1:0] ld_data,
  output logic          take,
  output logic          done,
  output logic          busy,
  output logic          txd
);
  tx_phase_e      phase;
  logic [DW-1:0]  shreg;
  logic [BCW-1:0] bitcnt;

  assign take = tick && avail && ((phase == PH_IDLE) || (phase == PH_STOP));
  assign done = tick && (phase == PH_STOP);
  assign busy = (phase != PH_IDLE);

  always_comb begin
    case (phase)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = shreg[0];
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
    end else if (tick) begin
      case (phase)
        PH_IDLE: begin
          if (avail) begin
            phase <= PH_START;
            shreg <= ld_data;
          end
        end
        PH_START: begin
          phase  <= PH_DATA;
          bitcnt <= '0;
        end
        PH_DATA: begin
          shreg <= shreg >> 1;
          if (bitcnt == BCW'(DW - 1)) phase <= PH_STOP;
          else bitcnt <= bitcnt + 1'b1;
        end
        default: begin
          if (avail) begin
            phase <= PH_START;
            shreg <= ld_data;
          end else begin
            phase <= PH_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_txb_bypass.sv
module uart_txb_bypass #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          imm_set,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          fifo_room,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_rdata,
  input  logic          take,
  input  logic          done,
  output logic          in_ready,
  output logic          fifo_push,
  output logic          fifo_pop,
  output logic          avail,
  output logic [DW-1:0] ld_data,
  output logic          imm_pending,
  output logic          ovf
);
  logic          imm_q;
  logic          claimed_q;
  logic          hold_full;
  logic [DW-1:0] hold_q;
  logic          cur_byp;

  wire route_byp = imm_q && !claimed_q;
  wire accept    = in_valid && in_ready;

  assign in_ready    = route_byp || fifo_room;
  assign fifo_push   = accept && !route_byp;
  assign avail       = hold_full || !fifo_empty;
  assign ld_data     = hold_full ? hold_q : fifo_rdata;
  assign fifo_pop    = take && !hold_full;
  assign imm_pending = imm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q     <= 1'b0;
      claimed_q <= 1'b0;
      hold_full <= 1'b0;
      hold_q    <= '0;
      cur_byp   <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (in_valid && !in_ready) ovf <= 1'b1;

      if (accept && route_byp) begin
        hold_q    <= in_data;
        hold_full <= 1'b1;
        claimed_q <= 1'b1;
      end else if (take && hold_full) begin
        hold_full <= 1'b0;
      end

      if (take) cur_byp <= hold_full;
      else if (done) cur_byp <= 1'b0;

      if (done && cur_byp) begin
        imm_q     <= 1'b0;
        claimed_q <= 1'b0;
      end else if (imm_set && fifo_en && !imm_q) begin
        imm_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_bypass.sv
module uart_tx_bypass #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          fifo_en,
  input  logic          rts_inv,
  input  logic          imm_set,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          txd,
  output logic          rts_n,
  output logic          imm_pending,
  output logic          ovf
);
  logic          fifo_push, fifo_pop, fifo_full, fifo_empty, fifo_room;
  logic [DW-1:0] fifo_rdata, ld_data;
  logic [CW-1:0] fifo_count;
  logic          avail, take, done, busy;

  assign fifo_room = fifo_en ? !fifo_full : fifo_empty;
  assign rts_n     = rts_inv ? busy : !busy;

  uart_txb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .wdata (in_data),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  uart_txb_bypass #(.DW(DW)) u_byp (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .imm_set     (imm_set),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .fifo_room   (fifo_room),
    .fifo_empty  (fifo_empty),
    .fifo_rdata  (fifo_rdata),
    .take        (take),
    .done        (done),
    .in_ready    (in_ready),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop),
    .avail       (avail),
    .ld_data     (ld_data),
    .imm_pending (imm_pending),
    .ovf         (ovf)
  );

  uart_txb_shifter #(.DW(DW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .avail   (avail),
    .ld_data (ld_data),
    .take    (take),
    .done    (done),
    .busy    (busy),
    .txd     (txd)
  );
endmodule

// File: rtl/uart_txb_checker.sv
module uart_txb_checker #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          baud_tick,
  input logic          fifo_en,
  input logic          rts_inv,
  input logic          in_valid,
  input logic          in_ready,
  input logic          txd,
  input logic          rts_n,
  input logic          imm_pending,
  input logic          ovf,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] fifo_count
);
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));

  assert_depth_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ovf);

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  assert_clear_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(imm_pending) |-> $past(done));

  assert_no_arm_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !imm_pending) |=> !imm_pending);

  assert_rts_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rts_inv) |-> !rts_n);

  assert_rts_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rts_inv) |-> rts_n);
endmodule

bind uart_tx_bypass uart_txb_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .baud_tick   (baud_tick),
  .fifo_en     (fifo_en),
  .rts_inv     (rts_inv),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .txd         (txd),
  .rts_n       (rts_n),
  .imm_pending (imm_pending),
  .ovf         (ovf),
  .busy        (busy),
  .done        (done),
  .fifo_count  (fifo_count)
);

// File: tb/sim_uart_tx_bypass.sv
`timescale 1ns/1ps
module sim_uart_tx_bypass;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       fifo_en = 1'b1;
  logic       rts_inv = 1'b0;
  logic       imm_set = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       txd, rts_n, imm_pending, ovf;

  int total = 0;
  int bad = 0;
  bit tick_en = 1'b0;
  logic tick_seen = 1'b0;
  int dstate = 0;
  logic [7:0] dsh = 8'h00;
  logic [7:0] rx_q[$];
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  uart_tx_bypass u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_en(fifo_en),
    .rts_inv(rts_inv), .imm_set(imm_set), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .txd(txd), .rts_n(rts_n),
    .imm_pending(imm_pending), .ovf(ovf)
  );

  function automatic logic rts_level(input logic inv, input logic sending);
    return sending ? inv : !inv;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = tick_en;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  always @(posedge clk) tick_seen <= baud_tick;

  // line decoder: after each tick, txd carries the next bit
  always @(negedge clk) begin
    if (rst_n && tick_seen) begin
      if (dstate == 0) begin
        if (txd == 1'b0) begin
          dstate = 1;
          chk("R10 rts at start", rts_n, rts_level(rts_inv, 1'b1));
        end else begin
          chk("R10 rts idle", rts_n, rts_level(rts_inv, 1'b0));
        end
      end else if (dstate <= 8) begin
        dsh[dstate-1] = txd;
        chk("R10 rts in data", rts_n, rts_level(rts_inv, 1'b1));
        dstate++;
      end else begin
        chk("R2 stop bit", txd, 1'b1);
        chk("R10 rts in stop", rts_n, rts_level(rts_inv, 1'b1));
        rx_q.push_back(dsh);
        dstate = 0;
      end
    end
  end

  task automatic put_byte(input logic [7:0] b, output bit acc);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    acc      = in_ready;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_imm();
    @(negedge clk);
    imm_set = 1'b1;
    @(negedge clk);
    imm_set = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      while (rx_q.size() == 0) @(negedge clk);
      chk(tag, rx_q.pop_front(), e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit acc;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd", txd, 1'b1);
    chk("R1 rts_n", rts_n, 1'b1);
    chk("R1 ovf", ovf, 1'b0);
    chk("R1 imm_pending", imm_pending, 1'b0);
    chk("R1 in_ready", in_ready, 1'b1);
    tick_en = 1'b1;

    // R2 directed frames
    foreach (exp_q[i]) ;
    put_byte(8'hA5, acc); exp_q.push_back(8'hA5);
    put_byte(8'h01, acc); exp_q.push_back(8'h01);
    put_byte(8'h80, acc); exp_q.push_back(8'h80);
    drain("R2 frame data");

    // R5/R6/R7 bypass overtakes the queue
    repeat (20) @(negedge clk);
    tick_en = 1'b0;
    repeat (8) @(negedge clk);
    put_byte(8'h11, acc);
    put_byte(8'h22, acc);
    put_byte(8'h33, acc);
    tick_en = 1'b1;
    while (rts_n !== 1'b0) @(negedge clk);
    pulse_imm();
    chk("R5 flag armed", imm_pending, 1'b1);
    put_byte(8'hC3, acc);
    chk("R5 bypass accepted", acc, 1'b1);
    pulse_imm();
    put_byte(8'h44, acc);
    chk("R7 flag held while waiting", imm_pending, 1'b1);
    exp_q.push_back(8'h11); exp_q.push_back(8'hC3);
    drain("R5 bypass order");
    exp_q.push_back(8'h22); exp_q.push_back(8'h33); exp_q.push_back(8'h44);
    drain("R6 later bytes queued");
    chk("R7 flag cleared", imm_pending, 1'b0);

    // R3/R4 full queue and drop
    repeat (20) @(negedge clk);
    tick_en = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      put_byte(b, acc);
      exp_q.push_back(b);
      if (!acc) chk("R3 accept while room", acc, 1'b1);
    end
    chk("R3 ready low when full", in_ready, 1'b0);
    chk("R4 ovf before drop", ovf, 1'b0);
    put_byte(8'h5A, acc);
    chk("R4 ovf after drop", ovf, 1'b1);
    tick_en = 1'b1;
    drain("R3 fifo order");
    repeat (60) @(negedge clk);
    chk("R4 dropped byte absent", rx_q.size(), 0);
    chk("R4 ovf sticky", ovf, 1'b1);

    // R8/R9 queue disabled
    tick_en = 1'b0;
    fifo_en = 1'b0;
    repeat (8) @(negedge clk);
    pulse_imm();
    chk("R8 flag not armed", imm_pending, 1'b0);
    put_byte(8'h6E, acc);
    chk("R9 first accepted", acc, 1'b1);
    chk("R9 ready low", in_ready, 1'b0);
    put_byte(8'h77, acc);
    chk("R9 second refused", acc, 1'b0);
    tick_en = 1'b1;
    exp_q.push_back(8'h6E);
    drain("R9 single byte");
    repeat (60) @(negedge clk);
    chk("R9 nothing extra", rx_q.size(), 0);
    fifo_en = 1'b1;

    // random stream with swapped direction polarity
    repeat (20) @(negedge clk);
    rts_inv = 1'b1;
    @(negedge clk);
    chk("R10 inverted idle", rts_n, 1'b0);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      repeat (30 + ($urandom % 50)) @(negedge clk);
      put_byte(b, acc);
      chk("R3 random accept", acc, 1'b1);
      exp_q.push_back(b);
    end
    drain("R2 random data");
    repeat (60) @(negedge clk);
    chk("R10 inverted idle end", rts_n, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule